// File: doc/BRIEF.md
# EEPROM Write Protection and Status Controller

This block sits beside the serial command engine of a small EEPROM and owns the status byte. It keeps the write-enable latch, the write-in-progress flag, a two-bit block-protect field and a protect-enable bit. For every write the engine presents, it decides whether that write may proceed. A write can target an array address or the status register. The decision combines four things: the latch, the state of the active-low write-protect pin, the protect-enable bit, and the address range that the block-protect field selects.

The engine holds a request level for the whole frame and reads `wr_permit_o` while it does so. When the frame ends legally, it pulses `wr_commit_i`. If the block accepts the commit, it updates the nonvolatile bits for a status write and starts an internal write timer. That timer keeps the busy flag high for a parameterised number of cycles. Any commit made while the block is idle clears the write-enable latch, whether it was accepted or refused. The nonvolatile bits are flops that reset to parameter values. No storage array is modelled.

Top module: `eeprom_wprot_ctrl`

## Requirements
- R1: After reset the status byte reads `{RST_PEN, 3'b000, RST_BP, 1'b0, 1'b0}` and busy is low. Status bit 0 is write-in-progress, bit 1 is the write-enable latch, bits 3:2 are block-protect and bit 7 is protect-enable.
- R2: When idle, a `wel_set_i` pulse sets status bit 1 and a `wel_clr_i` pulse clears it. If both arrive in the same cycle, the clear wins.
- R3: The block-protect field guards these address ranges: 00 guards none, 01 guards the top quarter (0xC00 to 0xFFF at 12 address bits), 10 guards the top half (0x800 up) and 11 guards all addresses. An array write inside the guarded range is never permitted.
- R4: While the write-enable latch is 0, neither an array write nor a status write is permitted.
- R5: With the latch at 1 and the block idle, an array write outside the guarded range is permitted whatever the pin and protect-enable state.
- R6: Hardware protection is active exactly when `wp_n_i` is low and protect-enable is 1. While it is active a status write is refused, so protect-enable cannot be cleared. Otherwise a status write is permitted when the latch is 1.
- R7: An accepted status write stores data bits 3:2 and 7 and discards bits 0, 1, 4, 5 and 6. Status bits 6:4 always read 0.
- R8: A commit made while idle with a request present always clears the latch. A refused commit changes nothing else and does not start the timer.
- R9: After an accepted commit, busy and status bit 0 go high in the next cycle and stay high for exactly `WRITE_CYCLES` cycles.
- R10: While busy, the permit is 0 and set, clear and commit inputs are ignored.
- R11: If a status request and an array request are both raised, the status request decides the permit and the commit.
- R12: A commit in the same cycle as a `wel_set_i` pulse takes priority, so the latch ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n_i | input | 1 | Write-protect pin, active low |
| wel_set_i | input | 1 | Set the write-enable latch |
| wel_clr_i | input | 1 | Clear the write-enable latch |
| arr_wr_req_i | input | 1 | Array write request level |
| arr_addr_i | input | ADDR_W | Array write address |
| sr_wr_req_i | input | 1 | Status write request level |
| sr_wdata_i | input | 8 | New status value |
| wr_commit_i | input | 1 | Frame ended legally, commit the request |
| status_o | output | 8 | Status byte |
| wr_permit_o | output | 1 | Current request is allowed |
| busy_o | output | 1 | Internal write in progress |

## Verification
Two pairs of inputs can land in the same cycle. The first is a latch-set pulse together with a commit. The bench drives both in one cycle and expects the latch to read 0 while the timer starts. The second is a set pulse together with a clear pulse, where the bench expects the clear to win. The bench also raises status and array requests together while the pin-and-enable lock is active, and expects a refusal even though the address is unguarded. It then commits inside a busy window and expects the status byte unchanged once the timer drains.

// File: rtl/eeprom_wprot_pkg.sv
package eeprom_wprot_pkg;

    localparam int SR_W = 8;
    localparam logic [SR_W-1:0] NV_MASK = 8'b1000_1100;

    typedef struct packed {
        logic [SR_W-1:0] nv;
        logic            wel;
    } ctrl_state_t;

    // number of guarded quarters for a block-protect code
    function automatic logic [2:0] bp_quarters(input logic [1:0] bp);
        case (bp)
            2'b01:   bp_quarters = 3'd1;
            2'b10:   bp_quarters = 3'd2;
            2'b11:   bp_quarters = 3'd4;
            default: bp_quarters = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/eeprom_wprot_region.sv
module eeprom_wprot_region
    import eeprom_wprot_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [1:0]        bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              in_region_o
);
    localparam int          LW    = ADDR_W + 1;
    localparam logic [LW-1:0] DEPTH = LW'(1) << ADDR_W;
    localparam logic [LW-1:0] QTR   = DEPTH >> 2;

    logic [LW-1:0] limit;

    always_comb begin
        limit       = DEPTH - (LW'(bp_quarters(bp_i)) * QTR);
        in_region_o = ({1'b0, addr_i} >= limit);
    end
endmodule

// File: rtl/eeprom_wprot_timer.sv
module eeprom_wprot_timer #(
    parameter int WRITE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(WRITE_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (t_q.busy) begin
            if (t_q.cnt == '0) t_d.busy = 1'b0;
            else               t_d.cnt  = t_q.cnt - 1'b1;
        end else if (start_i) begin
            t_d.busy = 1'b1;
            t_d.cnt  = LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy_o = t_q.busy;
endmodule

// File: rtl/eeprom_wprot_ctrl.sv
module eeprom_wprot_ctrl
    import eeprom_wprot_pkg::*;
#(
    parameter int         ADDR_W       = 12,
    parameter int         WRITE_CYCLES = 8,
    parameter logic [1:0] RST_BP       = 2'b00,
    parameter logic       RST_PEN      = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n_i,
    input  logic              wel_set_i,
    input  logic              wel_clr_i,
    input  logic              arr_wr_req_i,
    input  logic [ADDR_W-1:0] arr_addr_i,
    input  logic              sr_wr_req_i,
    input  logic [7:0]        sr_wdata_i,
    input  logic              wr_commit_i,
    output logic [7:0]        status_o,
    output logic              wr_permit_o,
    output logic              busy_o
);
    localparam logic [SR_W-1:0] NV_RST = {RST_PEN, 3'b000, RST_BP, 2'b00};

    ctrl_state_t st_d, st_q;

    logic in_region;
    logic busy;
    logic hw_lock;
    logic sr_sel, arr_sel, any_req;
    logic allow, accept;

    eeprom_wprot_region #(.ADDR_W(ADDR_W)) u_region (
        .bp_i        (st_q.nv[3:2]),
        .addr_i      (arr_addr_i),
        .in_region_o (in_region)
    );

    eeprom_wprot_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (accept),
        .busy_o  (busy)
    );

    always_comb begin
        hw_lock = !wp_n_i && st_q.nv[7];
        sr_sel  = sr_wr_req_i;
        arr_sel = arr_wr_req_i && !sr_wr_req_i;
        any_req = sr_sel || arr_sel;
        allow   = !busy && st_q.wel &&
                  (sr_sel ? !hw_lock : (arr_sel && !in_region));
        accept  = wr_commit_i && allow;

        st_d = st_q;
        if (!busy) begin
            if (wr_commit_i && any_req) begin
                st_d.wel = 1'b0;
                if (accept && sr_sel)
                    st_d.nv = sr_wdata_i & NV_MASK;
            end else if (wel_clr_i) begin
                st_d.wel = 1'b0;
            end else if (wel_set_i) begin
                st_d.wel = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.nv  <= NV_RST;
            st_q.wel <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o    = st_q.nv | {6'b0, st_q.wel, busy};
    assign wr_permit_o = allow;
    assign busy_o      = busy;
endmodule

// File: rtl/eeprom_wprot_ctrl_chk.sv
module eeprom_wprot_ctrl_chk #(
    parameter int ADDR_W       = 12,
    parameter int WRITE_CYCLES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp_n_i,
    input logic              arr_wr_req_i,
    input logic [ADDR_W-1:0] arr_addr_i,
    input logic              sr_wr_req_i,
    input logic              wr_commit_i,
    input logic [7:0]        status_o,
    input logic              wr_permit_o,
    input logic              busy_o
);
    localparam int RW = $clog2(WRITE_CYCLES + 2);

    logic [RW-1:0] run_q;
    logic [1:0]    top2;
    logic [1:0]    bp;
    logic          guarded;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               run_q <= '0;
        else if (!busy_o)                         run_q <= '0;
        else if (run_q != RW'(WRITE_CYCLES + 1))  run_q <= run_q + 1'b1;
    end

    always_comb begin
        top2    = arr_addr_i[ADDR_W-1 -: 2];
        bp      = status_o[3:2];
        guarded = (bp == 2'b11) || (bp == 2'b10 && top2[1]) ||
                  (bp == 2'b01 && top2 == 2'b11);
    end

    // R3
    region_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_req_i && !sr_wr_req_i && guarded) |-> !wr_permit_o);

    // R4
    no_wel_no_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[1] |-> !wr_permit_o);

    // R6
    hw_lock_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_req_i && !wp_n_i && status_o[7]) |-> !wr_permit_o);

    // R6
    pen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n_i && status_o[7]) |=> status_o[7]);

    // R8
    commit_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit_i && (arr_wr_req_i || sr_wr_req_i) && !busy_o) |=> !status_o[1]);

    // R9
    accept_starts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit_i && wr_permit_o) |=> (busy_o && status_o[0]));

    // R9
    busy_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (run_q < RW'(WRITE_CYCLES)));

    // R9
    busy_len_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_q == RW'(WRITE_CYCLES)));

    // R10
    busy_no_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !wr_permit_o);

endmodule

bind eeprom_wprot_ctrl eeprom_wprot_ctrl_chk #(
    .ADDR_W       (ADDR_W),
    .WRITE_CYCLES (WRITE_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wp_n_i       (wp_n_i),
    .arr_wr_req_i (arr_wr_req_i),
    .arr_addr_i   (arr_addr_i),
    .sr_wr_req_i  (sr_wr_req_i),
    .wr_commit_i  (wr_commit_i),
    .status_o     (status_o),
    .wr_permit_o  (wr_permit_o),
    .busy_o       (busy_o)
);

// File: tb/eeprom_wprot_ctrl_tb.sv
module eeprom_wprot_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int WCYC       = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wp_n = 1'b1;
    logic              wel_set = 1'b0;
    logic              wel_clr = 1'b0;
    logic              arr_req = 1'b0;
    logic [ADDR_W-1:0] arr_addr = '0;
    logic              sr_req = 1'b0;
    logic [7:0]        sr_wdata = '0;
    logic              commit = 1'b0;
    logic [7:0]        status;
    logic              permit;
    logic              busy;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    eeprom_wprot_ctrl #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WCYC)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wp_n_i       (wp_n),
        .wel_set_i    (wel_set),
        .wel_clr_i    (wel_clr),
        .arr_wr_req_i (arr_req),
        .arr_addr_i   (arr_addr),
        .sr_wr_req_i  (sr_req),
        .sr_wdata_i   (sr_wdata),
        .wr_commit_i  (commit),
        .status_o     (status),
        .wr_permit_o  (permit),
        .busy_o       (busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_set();
        wel_set = 1'b1; step(); wel_set = 1'b0;
    endtask

    task automatic pulse_clr();
        wel_clr = 1'b1; step(); wel_clr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && busy; i++) step();
    endtask

    task automatic commit_sr(input logic [7:0] d);
        sr_req = 1'b1; sr_wdata = d; commit = 1'b1;
        step();
        commit = 1'b0; sr_req = 1'b0;
    endtask

    function automatic logic guarded(input logic [1:0] bp, input int a);
        case (bp)
            2'b01:   guarded = (a >= 'hC00);
            2'b10:   guarded = (a >= 'h800);
            2'b11:   guarded = 1'b1;
            default: guarded = 1'b0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        // R1 reset state
        chk("R1 status", status, 8'h00);
        chk("R1 busy", busy, 0);
        rst_n = 1'b1;
        step();

        // R2 latch control
        pulse_set();  chk("R2 set", status[1], 1);
        pulse_clr();  chk("R2 clr", status[1], 0);
        pulse_set();
        wel_set = 1'b1; wel_clr = 1'b1; step(); wel_set = 1'b0; wel_clr = 1'b0;
        chk("R2 clr wins", status[1], 0);

        // R7 reserved bits dropped, R9 busy window
        pulse_set();
        commit_sr(8'hFF);
        chk("R7 status after write", status, 8'h8D);
        for (int i = 0; i < WCYC; i++) begin
            chk("R9 busy high", busy, 1);
            step();
        end
        chk("R9 busy low", busy, 0);
        chk("R9 status idle", status, 8'h8C);

        // R10 inputs ignored while busy
        pulse_set();
        commit_sr(8'h00);
        arr_req = 1'b1; arr_addr = '0; #1;
        chk("R10 no permit busy", permit, 0);
        arr_req = 1'b0;
        pulse_set();
        chk("R10 set ignored", status[1], 0);
        commit_sr(8'h8C);
        wait_idle();
        chk("R10 commit ignored", status, 8'h00);

        // R6 enable locks itself, R8 refused commit
        pulse_set();
        commit_sr(8'h80);
        wait_idle();
        wp_n = 1'b0;
        pulse_set();
        sr_req = 1'b1; sr_wdata = 8'h00; #1;
        chk("R6 sr refused", permit, 0);
        // R11 status request dominates array request
        arr_req = 1'b1; arr_addr = '0; #1;
        chk("R11 sr priority", permit, 0);
        arr_req = 1'b0;
        commit = 1'b1; step(); commit = 1'b0; sr_req = 1'b0;
        chk("R8 wel cleared", status[1], 0);
        chk("R8 no busy", busy, 0);
        chk("R6 pen kept", status, 8'h80);
        wp_n = 1'b1;
        pulse_set();
        sr_req = 1'b1; arr_req = 1'b1; arr_addr = '0; #1;
        chk("R11 sr allowed", permit, 1);
        sr_req = 1'b0; arr_req = 1'b0;

        // R12 commit beats set
        arr_req = 1'b1; arr_addr = '0; commit = 1'b1; wel_set = 1'b1;
        step();
        arr_req = 1'b0; commit = 1'b0; wel_set = 1'b0;
        chk("R12 wel zero", status[1], 0);
        chk("R12 busy started", busy, 1);
        wait_idle();

        // sweep of R3 R4 R5 R6
        for (int bp = 0; bp < 4; bp++) begin
            for (int pen = 0; pen < 2; pen++) begin
                wp_n = 1'b1;
                pulse_set();
                commit_sr({pen[0], 3'b000, bp[1:0], 2'b00});
                wait_idle();
                chk("R7 stored", status, {pen[0], 3'b000, bp[1:0], 2'b00});
                for (int wel = 0; wel < 2; wel++) begin
                    if (wel == 1) pulse_set(); else pulse_clr();
                    for (int wp = 0; wp < 2; wp++) begin
                        wp_n = wp[0];
                        #1;
                        for (int a = 0; a < (1 << ADDR_W); a += 64) begin
                            for (int k = 0; k < 2; k++) begin
                                int ad;
                                ad = (k == 0) ? a : a + 63;
                                arr_req = 1'b1; arr_addr = ad[ADDR_W-1:0]; #1;
                                if (wel == 0)
                                    chk("R4 arr", permit, 0);
                                else if (guarded(bp[1:0], ad))
                                    chk("R3 arr guarded", permit, 0);
                                else
                                    chk("R5 arr open", permit, 1);
                            end
                        end
                        arr_req = 1'b0;
                        sr_req = 1'b1; #1;
                        chk("R6 sr permit", permit,
                            (wel == 1) && !((wp == 0) && (pen == 1)));
                        sr_req = 1'b0; #1;
                    end
                end
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule